// File: doc/BRIEF.md
# Serial Stuck-At Fault Grader

This block measures how well a set of test vectors exposes single stuck-at faults in a small, fixed combinational circuit that is built into the block as gate-level logic. Each circuit line passes through its own injection multiplexer, so any one line can be forced to 0 or 1. The host loads up to 16 four-bit vectors through a write port, sets how many of them to use, and pulses start. The block first runs the vectors through the circuit with no fault and records the two output bits for each vector as reference responses. It then takes the faults one at a time in ascending index order. For each fault it forces the fault and replays the vectors, one per clock, comparing each response against the stored reference.

When a response differs, the fault is flagged and its remaining vectors are skipped. A fault whose vectors all match keeps a zero flag. When the last fault has been handled, the block raises done. The host then reads the 16-bit detection map and the count of detected faults. Coverage is the count divided by 16, and the zero bits of the map name the faults the vectors missed.

The controller is a three-state machine. IDLE waits for start. GOLD records reference responses. GRADE replays vectors with a fault injected. The transitions are as follows:
- LAUNCH: IDLE to GOLD, on start with a non-zero vector count.
- EMPTY: IDLE to IDLE, on start with a zero count; done is set at once.
- GOLD_END: GOLD to GRADE, after the last vector has been recorded.
- NEXT_FAULT: GRADE to GRADE, when a fault is detected or has run out of vectors and it is not the last fault.
- FINISH: GRADE to IDLE, when the last fault ends; done is set.

Top module: `fault_grader`

## Requirements
- R1: While reset is held and right after it, busy, done, the detection map and the detected count are all 0.
- R2: A start pulse in IDLE with an effective vector count N > 0 clears the map, the count and done. Busy rises on the same edge. The GOLD phase then lasts exactly N clock cycles, recording the response to vector v in cycle v.
- R3: Fault index k forces line k>>1 to the value k&1. Lines 0 to 3 are vector bits 0 to 3 (a, b, c, d). The gates are: line 4 = a AND b, line 5 = c OR d, line 6 = NOT(line4 AND line5), line 7 = line4 XOR line5. Output bit 0 is line 6 and output bit 1 is line 7. A forced line feeds every gate that reads it. Only the selected line is forced.
- R4: In GRADE the faults run in ascending index order, 0 to 15. Each vector comparison takes one clock, in vector order, against that vector's stored reference response.
- R5: On the first mismatch for a fault, its map bit is set, the count rises by exactly 1, and the next fault starts on the following clock with vector 0.
- R6: A fault with no mismatch over all N vectors keeps its map bit at 0 and takes N clocks. The count always equals the number of set map bits.
- R7: When fault 15 ends, busy falls and done rises on the same edge. Busy and done are never high together.
- R8: A start pulse while busy is ignored: the run, the map and the count continue unchanged.
- R9: Vector memory writes take effect only while idle; writes while busy are ignored.
- R10: Start with a vector count of 0 sets done on the next edge, leaves busy low, and leaves the map and count at 0.
- R11: A vector count above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| vec_we_i | input | 1 | Vector memory write enable |
| vec_addr_i | input | 4 | Vector memory write address |
| vec_data_i | input | 4 | Vector written (bit i drives line i) |
| vec_count_i | input | 5 | Number of vectors to use, sampled at start |
| busy_o | output | 1 | Grading run in progress |
| done_o | output | 1 | Run finished; cleared by the next accepted start |
| detected_o | output | 16 | Bit k set when fault k was detected |
| det_count_o | output | 5 | Number of detected faults |

## Verification
The assertions assume the host holds the vector count and memory contents steady in a meaningful way only while idle. They also assume start and write requests are sampled on clock edges, with no constraint on when start may arrive. The stimulus writes vectors only between runs, except in one deliberate case that writes and pulses start mid-run to show both are ignored. The count input is driven with 0, 1, small values, 16 and an out-of-range value. A behavioural model tracks phase, vector index, fault index and results every clock, and the outputs are compared against it on each cycle.

// File: rtl/fg_pkg.sv
package fg_pkg;
    localparam int IN_W   = 4;
    localparam int OUT_W  = 2;
    localparam int LINES  = 8;
    localparam int LINE_W = $clog2(LINES);
    localparam int FAULTS = 2 * LINES;
    localparam int FIDX_W = LINE_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GOLD  = 2'd1,
        ST_GRADE = 2'd2
    } gr_state_e;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              stuck;
    } fault_t;
endpackage

// File: rtl/fg_store.sv
module fg_store #(
    parameter int DEPTH = 16,
    parameter int W     = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fg_cut.sv
module fg_cut
    import fg_pkg::*;
(
    input  logic [IN_W-1:0]  vec_i,
    input  logic             inj_en_i,
    input  fault_t           flt_i,
    output logic [OUT_W-1:0] y_o
);
    logic [LINES-1:0] hit;
    logic l0, l1, l2, l3, l4, l5, l6, l7;

    for (genvar i = 0; i < LINES; i++) begin : g_sel
        assign hit[i] = inj_en_i && (flt_i.line == LINE_W'(i));
    end

    // each line passes through its own injection multiplexer
    assign l0 = hit[0] ? flt_i.stuck : vec_i[0];
    assign l1 = hit[1] ? flt_i.stuck : vec_i[1];
    assign l2 = hit[2] ? flt_i.stuck : vec_i[2];
    assign l3 = hit[3] ? flt_i.stuck : vec_i[3];
    assign l4 = hit[4] ? flt_i.stuck : (l0 & l1);
    assign l5 = hit[5] ? flt_i.stuck : (l2 | l3);
    assign l6 = hit[6] ? flt_i.stuck : ~(l4 & l5);
    assign l7 = hit[7] ? flt_i.stuck : (l4 ^ l5);

    assign y_o = {l7, l6};
endmodule

// File: rtl/fault_grader.sv
module fault_grader
    import fg_pkg::*;
#(
    parameter int VEC_DEPTH = 16,
    localparam int VA_W  = $clog2(VEC_DEPTH),
    localparam int CNT_W = $clog2(VEC_DEPTH + 1),
    localparam int FC_W  = $clog2(FAULTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              vec_we_i,
    input  logic [VA_W-1:0]   vec_addr_i,
    input  logic [IN_W-1:0]   vec_data_i,
    input  logic [CNT_W-1:0]  vec_count_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [FAULTS-1:0] detected_o,
    output logic [FC_W-1:0]   det_count_o
);
    gr_state_e          state_q, state_d;
    logic [VA_W-1:0]    vidx_q;
    logic [FIDX_W-1:0]  fidx_q;
    logic [CNT_W-1:0]   vcnt_q;
    logic [FAULTS-1:0]  detected_q;
    logic [FC_W-1:0]    detcnt_q;
    logic               done_q;

    logic [CNT_W-1:0]   cnt_in;
    logic               last_vec, last_flt, mismatch, flt_end;
    logic [IN_W-1:0]    vec_rd;
    logic [OUT_W-1:0]   gold_rd, cut_y;
    logic               vec_wr_ok, gold_we, inj_en;
    fault_t             cur_flt;

    assign cnt_in   = (vec_count_i > CNT_W'(VEC_DEPTH)) ? CNT_W'(VEC_DEPTH) : vec_count_i;
    assign last_vec = (CNT_W'(vidx_q) + CNT_W'(1)) == vcnt_q;
    assign last_flt = fidx_q == FIDX_W'(FAULTS - 1);
    assign inj_en   = (state_q == ST_GRADE);
    assign gold_we  = (state_q == ST_GOLD);
    assign vec_wr_ok = vec_we_i && (state_q == ST_IDLE);
    assign cur_flt  = fault_t'(fidx_q);
    assign mismatch = inj_en && (cut_y != gold_rd);
    assign flt_end  = mismatch || last_vec;

    fg_store #(.DEPTH(VEC_DEPTH), .W(IN_W)) u_vec (
        .clk     (clk),
        .we_i    (vec_wr_ok),
        .waddr_i (vec_addr_i),
        .wdata_i (vec_data_i),
        .raddr_i (vidx_q),
        .rdata_o (vec_rd)
    );

    fg_store #(.DEPTH(VEC_DEPTH), .W(OUT_W)) u_gold (
        .clk     (clk),
        .we_i    (gold_we),
        .waddr_i (vidx_q),
        .wdata_i (cut_y),
        .raddr_i (vidx_q),
        .rdata_o (gold_rd)
    );

    fg_cut u_cut (
        .vec_i    (vec_rd),
        .inj_en_i (inj_en),
        .flt_i    (cur_flt),
        .y_o      (cut_y)
    );

    // next-state decode: LAUNCH, EMPTY, GOLD_END, NEXT_FAULT, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i && (cnt_in != '0)) state_d = ST_GOLD;
            ST_GOLD:  if (last_vec) state_d = ST_GRADE;
            ST_GRADE: if (flt_end && last_flt) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vidx_q     <= '0;
            fidx_q     <= '0;
            vcnt_q     <= '0;
            detected_q <= '0;
            detcnt_q   <= '0;
            done_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        detected_q <= '0;
                        detcnt_q   <= '0;
                        vidx_q     <= '0;
                        fidx_q     <= '0;
                        vcnt_q     <= cnt_in;
                        done_q     <= (cnt_in == '0);
                    end
                end
                ST_GOLD: begin
                    vidx_q <= last_vec ? '0 : vidx_q + VA_W'(1);
                end
                ST_GRADE: begin
                    if (mismatch) begin
                        detected_q[fidx_q] <= 1'b1;
                        detcnt_q           <= detcnt_q + FC_W'(1);
                    end
                    if (flt_end) begin
                        vidx_q <= '0;
                        fidx_q <= fidx_q + FIDX_W'(1);
                        if (last_flt) done_q <= 1'b1;
                    end else begin
                        vidx_q <= vidx_q + VA_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign detected_o  = detected_q;
    assign det_count_o = detcnt_q;

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R2
    launch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (detected_o == '0 && det_count_o == '0 && !done_o));

    // R5
    skip_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRADE && mismatch) |=> (vidx_q == '0));

    // R6
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(detected_o) == int'(det_count_o));

    // R5
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ((detected_o & $past(detected_o)) == $past(detected_o)));

    // R8
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRADE && start_i) |=> (state_q != ST_GOLD));

    // R4
    gold_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GOLD) |=> busy_o);
endmodule

// File: tb/sim_fault_grader.sv
module sim_fault_grader;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        vec_we_i = 1'b0;
    logic [3:0]  vec_addr_i = '0;
    logic [3:0]  vec_data_i = '0;
    logic [4:0]  vec_count_i = '0;
    logic        busy_o, done_o;
    logic [15:0] detected_o;
    logic [4:0]  det_count_o;

    fault_grader u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_we_i(vec_we_i),
        .vec_addr_i(vec_addr_i), .vec_data_i(vec_data_i), .vec_count_i(vec_count_i),
        .busy_o(busy_o), .done_o(done_o), .detected_o(detected_o), .det_count_o(det_count_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural circuit: fault on line ln forces it to st
    function automatic bit [1:0] ref_cut(bit [3:0] v, bit inj, int ln, bit st);
        bit n [8];
        for (int i = 0; i < 8; i++) begin
            case (i)
                4: n[i] = n[0] & n[1];
                5: n[i] = n[2] | n[3];
                6: n[i] = !(n[4] & n[5]);
                7: n[i] = n[4] ^ n[5];
                default: n[i] = v[i];
            endcase
            if (inj && ln == i) n[i] = st;
        end
        return {n[7], n[6]};
    endfunction

    // reference model state: mode 0 idle, 1 golden, 2 grading
    int        m_mode, m_v, m_f, m_cnt, m_dc;
    bit [15:0] m_det;
    bit        m_done;
    bit [3:0]  m_vec [16];
    bit [1:0]  m_gold [16];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_v = 0; m_f = 0; m_cnt = 0; m_dc = 0; m_det = '0; m_done = 0;
        end else begin
            case (m_mode)
                0: begin
                    if (vec_we_i) m_vec[vec_addr_i] = vec_data_i;
                    if (start_i) begin
                        m_det = '0; m_dc = 0; m_v = 0; m_f = 0;
                        m_cnt = (vec_count_i > 16) ? 16 : int'(vec_count_i);
                        m_done = (m_cnt == 0);
                        if (m_cnt != 0) m_mode = 1;
                    end
                end
                1: begin
                    m_gold[m_v] = ref_cut(m_vec[m_v], 1'b0, 0, 1'b0);
                    if (m_v == m_cnt - 1) begin m_v = 0; m_mode = 2; end
                    else m_v++;
                end
                default: begin
                    bit hit;
                    hit = ref_cut(m_vec[m_v], 1'b1, m_f >> 1, m_f[0]) != m_gold[m_v];
                    if (hit) begin m_det[m_f] = 1'b1; m_dc++; end
                    if (hit || m_v == m_cnt - 1) begin
                        m_v = 0;
                        if (m_f == 15) begin m_mode = 0; m_done = 1; end
                        else m_f++;
                    end else m_v++;
                end
            endcase
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy_o == (m_mode != 0), "R2/R4 busy", busy_o, m_mode != 0);
            check(done_o == m_done, "R7 done", done_o, m_done);
            check(detected_o == m_det, "R5/R6 detected map", detected_o, m_det);
            check(int'(det_count_o) == m_dc, "R5 detected count", det_count_o, m_dc);
        end
    end

    task automatic put_vec(input int a, input bit [3:0] d);
        @(negedge clk);
        vec_we_i = 1'b1; vec_addr_i = 4'(a); vec_data_i = d;
        @(negedge clk);
        vec_we_i = 1'b0;
    endtask

    task automatic pulse_start(input int cnt);
        @(negedge clk);
        vec_count_i = 5'(cnt); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int k = 0;
        while (!(done_o && !busy_o) && k < 3000) begin
            @(negedge clk);
            k++;
        end
        check(k < 3000, tag, k, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog expired actual=busy expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit [15:0] first_map;
        bit [15:0] full_map;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && detected_o == 0 && det_count_o == 0, "R1 reset state",
              {busy_o, done_o, detected_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && detected_o == 0, "R1 after reset", {busy_o, done_o}, 0);

        // R3 single all-zero vector: faults 5,7,9,11,12,15 are exposed
        put_vec(0, 4'b0000);
        pulse_start(1);
        check(busy_o && !done_o, "R2 busy after start", busy_o, 1);
        wait_done("R7 run one finishes");
        check(detected_o == 16'h9AA0, "R3 single-vector map", detected_o, 16'h9AA0);
        check(det_count_o == 5'd6, "R3 single-vector count", det_count_o, 6);

        // several patterns
        put_vec(0, 4'b1111); put_vec(1, 4'b1010); put_vec(2, 4'b0101);
        put_vec(3, 4'b1100); put_vec(4, 4'b0011); put_vec(5, 4'b0110);
        pulse_start(6);
        wait_done("R7 run six finishes");
        first_map = detected_o;
        check($countones(detected_o) == int'(det_count_o), "R6 count equals set bits",
              det_count_o, $countones(detected_o));

        // R8 and R9: mid-run start and writes are ignored
        pulse_start(6);
        repeat (12) @(negedge clk);
        put_vec(0, 4'b0000);
        pulse_start(2);
        check(busy_o, "R8 still busy after mid-run start", busy_o, 1);
        wait_done("R7 run with interference finishes");
        check(detected_o == first_map, "R8 mid-run start ignored", detected_o, first_map);
        pulse_start(6);
        wait_done("R7 repeat run finishes");
        check(detected_o == first_map, "R9 mid-run write ignored", detected_o, first_map);

        // R10 empty run
        pulse_start(0);
        check(done_o && !busy_o && detected_o == 0 && det_count_o == 0, "R10 zero count",
              {done_o, busy_o, detected_o}, 32'h20000);
        @(negedge clk);
        check(!busy_o, "R10 stays idle", busy_o, 0);

        // exhaustive set, then R11 clamp
        for (int i = 0; i < 16; i++) put_vec(i, 4'(i));
        pulse_start(16);
        wait_done("R7 full run finishes");
        full_map = detected_o;
        pulse_start(20);
        check(busy_o, "R11 over-range count starts run", busy_o, 1);
        wait_done("R7 clamped run finishes");
        check(detected_o == full_map, "R11 clamp to 16", detected_o, full_map);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule